// File: doc/BRIEF.md
# Four-Slot Transmit Slot Engine

This block holds four transmit slots that a host fills one after another and that a transmitter finishes in the same rotating order. Each slot has a 32-bit buffer-address register and a 32-bit status/command register, both reachable over a simple single-cycle register bus. A host write to a slot's status register records a frame length and an early-start threshold and hands the slot to the transmitter. The register reads back the progress of that frame: the ownership flag, the outcome and the collision count.

The transmitter here is a behavioural stand-in. It moves the frame's byte count into a modelled FIFO at `FILL_BPC` bytes per cycle. Once enough bytes are buffered, it drains them onto a modelled wire at `SEND_BPC` bytes per cycle. Injection inputs let a test force an underrun, an abort or a collision count on the next frame to start. Each finished slot raises a single-cycle transmit-OK or transmit-error request. A software-reset command in a control register cancels everything in flight and rewinds the rotation to slot 0.

Top module: `tx_slot_engine`

## Requirements
- R1: After reset, all eight slot registers read 0, both interrupt requests are low and `tx_busy_o` is low.
- R2: Address registers sit at byte offsets 0x10 + 4·n for slot n. They read back the full 32-bit value written and do not start a transmission.
- R3: Status registers sit at byte offsets 0x00 + 4·n. A write keeps only the length in bits [12:0] and the threshold in bits [21:16]. All other bits read 0 until the slot's frame progresses.
- R4: Bit 13 (ownership) becomes 1 once the whole frame length has been moved into the FIFO. This happens before the slot's outcome bits appear.
- R5: The threshold counts 32-byte units. With a nonzero threshold below the length, `tx_busy_o` rises before bit 13 is set. With a threshold of 0, the wire starts only after the frame is fully buffered.
- R6: A clean completion sets bit 15 and leaves bits 14, 28, 29, 30 and 31 at 0. It copies the injected collision count into bits [27:24] and pulses `tx_ok_irq_o`.
- R7: With `inj_underrun_i` high when the frame starts, the slot ends with bit 14 set, bit 15 clear and a `tx_err_irq_o` pulse.
- R8: With `inj_abort_i` high when the frame starts, the slot ends with bit 30 set, bit 15 clear and a `tx_err_irq_o` pulse. Abort takes precedence over underrun.
- R9: Slots are served strictly in the order 0, 1, 2, 3, 0. A slot queued out of turn waits, untouched, until every earlier slot has finished.
- R10: A status write to a slot that is still queued or in progress is ignored.
- R11: Writing 1 to bit 0 of the control register at 0x20 clears every status register and all queued work, drops `tx_busy_o`, and rewinds the rotation to slot 0. The address registers keep their values.
- R12: Each finished slot produces exactly one interrupt pulse, one cycle wide, and the two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| inj_underrun_i | input | 1 | Force an underrun outcome on the next frame to start |
| inj_abort_i | input | 1 | Force an abort outcome on the next frame to start |
| inj_coll_i | input | 4 | Collision count reported by the next frame to start |
| tx_busy_o | output | 1 | Modelled wire is carrying the current frame |
| tx_ok_irq_o | output | 1 | One-cycle pulse on a clean completion |
| tx_err_irq_o | output | 1 | One-cycle pulse on a failed completion |

## Verification
A rotation pointer stuck on the wrong slot shows at the ports as a queued slot whose ownership bit never rises. It can also show as a later slot finishing before an earlier one, visible within one frame time. Stale queue bits show up right after a software reset as a slot that starts without being written, or a write that is refused. A wrong fill or drain count shows up within a few dozen cycles in two ways: the ownership bit and `tx_busy_o` rise in the wrong order relative to the threshold, or the interrupt pulse count no longer matches the number of finished slots.

// File: rtl/tx_slot_pkg.sv
package tx_slot_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int LEN_W     = 13;
  localparam int THR_W     = 6;
  localparam int THR_LSB   = 16;
  localparam int COLL_LSB  = 24;
  localparam int OWN_BIT   = 13;
  localparam int UNDER_BIT = 14;
  localparam int OK_BIT    = 15;
  localparam int ABORT_BIT = 30;
  localparam int CNT_W     = LEN_W + 1;

  localparam logic [5:0] STAT_BASE = 6'h00;
  localparam logic [5:0] ADDR_BASE = 6'h10;
  localparam logic [5:0] CTRL_ADDR = 6'h20;

  typedef struct packed {
    logic       underrun;
    logic       abort;
    logic [3:0] coll;
  } tx_result_t;
endpackage

// File: rtl/tx_frame_model.sv
module tx_frame_model
  import tx_slot_pkg::*;
#(
  parameter int FILL_BPC = 16,
  parameter int SEND_BPC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [THR_W-1:0] thr_i,
  input  tx_result_t       inj_i,
  output logic             own_o,
  output logic             done_o,
  output tx_result_t       res_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] FILL_STEP = CNT_W'(FILL_BPC);
  localparam logic [CNT_W-1:0] SEND_STEP = CNT_W'(SEND_BPC);

  logic             run_q, filled_q, sending_q;
  logic [CNT_W-1:0] fill_q, sent_q, len_q, early_q;
  logic             thr_zero_q;
  tx_result_t       res_q;

  logic [CNT_W-1:0] fill_sum, fill_nx, sent_sum, sent_nx;

  always_comb begin
    fill_sum = fill_q + FILL_STEP;
    fill_nx  = (fill_sum > len_q) ? len_q : fill_sum;
    sent_sum = sent_q + SEND_STEP;
    sent_nx  = (sent_sum > fill_q) ? fill_q : sent_sum;
  end

  assign own_o  = run_q && !filled_q && (fill_nx == len_q);
  assign done_o = run_q && sending_q && (sent_nx == len_q);
  assign res_o  = res_q;
  assign busy_o = sending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; filled_q <= 1'b0; sending_q <= 1'b0;
      fill_q <= '0; sent_q <= '0; len_q <= '0; early_q <= '0;
      thr_zero_q <= 1'b1; res_q <= '0;
    end else if (flush_i) begin
      run_q <= 1'b0; filled_q <= 1'b0; sending_q <= 1'b0;
      fill_q <= '0; sent_q <= '0;
    end else if (start_i) begin
      run_q      <= 1'b1;
      filled_q   <= 1'b0;
      sending_q  <= 1'b0;
      fill_q     <= '0;
      sent_q     <= '0;
      len_q      <= CNT_W'(len_i);
      early_q    <= CNT_W'({thr_i, 5'b0});
      thr_zero_q <= (thr_i == '0);
      res_q      <= inj_i;
    end else if (run_q) begin
      fill_q <= fill_nx;
      if (own_o) filled_q <= 1'b1;
      if (!sending_q && ((fill_nx == len_q) || (!thr_zero_q && fill_nx >= early_q)))
        sending_q <= 1'b1;
      if (sending_q) sent_q <= sent_nx;
      if (done_o) begin
        run_q     <= 1'b0;
        sending_q <= 1'b0;
      end
    end
  end

  a_r5_sent_le_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_q <= fill_q);
  a_r4_done_after_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> filled_q);
  a_r5_busy_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q);
endmodule

// File: rtl/tx_slot_seq.sv
module tx_slot_seq
  import tx_slot_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic [NUM_SLOTS-1:0] queue_i,
  input  logic                 done_i,
  input  logic                 done_ok_i,
  output logic [NUM_SLOTS-1:0] pending_o,
  output logic [SLOT_W-1:0]    ptr_o,
  output logic                 start_o,
  output logic                 ok_irq_o,
  output logic                 err_irq_o
);
  logic [NUM_SLOTS-1:0] pending_q;
  logic [SLOT_W-1:0]    ptr_q;
  logic                 active_q;

  assign start_o   = !active_q && pending_q[ptr_q] && !flush_i;
  assign pending_o = pending_q;
  assign ptr_o     = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= '0; ptr_q <= '0; active_q <= 1'b0;
      ok_irq_o <= 1'b0; err_irq_o <= 1'b0;
    end else if (flush_i) begin
      pending_q <= '0; ptr_q <= '0; active_q <= 1'b0;
      ok_irq_o <= 1'b0; err_irq_o <= 1'b0;
    end else begin
      ok_irq_o  <= done_i && done_ok_i;
      err_irq_o <= done_i && !done_ok_i;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (queue_i[i]) pending_q[i] <= 1'b1;
      end
      if (start_o) active_q <= 1'b1;
      if (done_i) begin
        pending_q[ptr_q] <= 1'b0;
        ptr_q            <= ptr_q + 1'b1;
        active_q         <= 1'b0;
      end
    end
  end

  a_r12_irq_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_irq_o && err_irq_o));
  a_r12_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_irq_o || err_irq_o) |=> !(ok_irq_o || err_irq_o));
  a_r9_done_in_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (active_q && pending_q[ptr_q]));
  a_r9_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !flush_i) |=> ptr_q == $past(ptr_q) + 1'b1);
  a_r11_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (pending_q == '0 && ptr_q == '0 && !active_q));
endmodule

// File: rtl/tx_slot_regs.sv
module tx_slot_regs
  import tx_slot_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [5:0]           addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_SLOTS-1:0] pending_i,
  input  logic [SLOT_W-1:0]    ptr_i,
  input  logic                 own_i,
  input  logic                 done_i,
  input  tx_result_t           res_i,
  output logic [NUM_SLOTS-1:0] queue_o,
  output logic                 flush_o,
  output logic [LEN_W-1:0]     len_o,
  output logic [THR_W-1:0]     thr_o
);
  logic [31:0] stat_q [NUM_SLOTS];
  logic [31:0] addr_q [NUM_SLOTS];
  logic [SLOT_W-1:0] sel;
  logic stat_hit, addr_hit;

  assign sel      = addr_i[2+:SLOT_W];
  assign stat_hit = addr_i[5:4] == STAT_BASE[5:4];
  assign addr_hit = addr_i[5:4] == ADDR_BASE[5:4];
  assign flush_o  = we_i && (addr_i == CTRL_ADDR) && wdata_i[0];

  assign len_o = stat_q[ptr_i][LEN_W-1:0];
  assign thr_o = stat_q[ptr_i][THR_LSB+:THR_W];

  always_comb begin
    rdata_o = '0;
    if (stat_hit)      rdata_o = stat_q[sel];
    else if (addr_hit) rdata_o = addr_q[sel];
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic wr_stat, wr_addr, is_cur;
    assign wr_stat    = we_i && stat_hit && (sel == SLOT_W'(g)) && !pending_i[g];
    assign wr_addr    = we_i && addr_hit && (sel == SLOT_W'(g));
    assign is_cur     = ptr_i == SLOT_W'(g);
    assign queue_o[g] = wr_stat && !flush_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q[g] <= '0;
        addr_q[g] <= '0;
      end else begin
        if (wr_addr) addr_q[g] <= wdata_i;
        if (flush_o) begin
          stat_q[g] <= '0;
        end else if (wr_stat) begin
          stat_q[g] <= '0;
          stat_q[g][LEN_W-1:0]       <= wdata_i[LEN_W-1:0];
          stat_q[g][THR_LSB+:THR_W]  <= wdata_i[THR_LSB+:THR_W];
        end else if (is_cur) begin
          if (own_i) stat_q[g][OWN_BIT] <= 1'b1;
          if (done_i) begin
            stat_q[g][ABORT_BIT]       <= res_i.abort;
            stat_q[g][UNDER_BIT]       <= !res_i.abort && res_i.underrun;
            stat_q[g][OK_BIT]          <= !res_i.abort && !res_i.underrun;
            stat_q[g][COLL_LSB+:4]     <= res_i.coll;
          end
        end
      end
    end

    a_r10_pending_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && stat_hit && sel == SLOT_W'(g) && pending_i[g] && !flush_o && !(is_cur && (own_i || done_i)))
        |=> stat_q[g] == $past(stat_q[g]));
  end

  a_r4_own_before_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> stat_q[ptr_i][OWN_BIT]);
endmodule

// File: rtl/tx_slot_engine.sv
module tx_slot_engine
  import tx_slot_pkg::*;
#(
  parameter int FILL_BPC = 16,
  parameter int SEND_BPC = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [5:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        inj_underrun_i,
  input  logic        inj_abort_i,
  input  logic [3:0]  inj_coll_i,
  output logic        tx_busy_o,
  output logic        tx_ok_irq_o,
  output logic        tx_err_irq_o
);
  logic [NUM_SLOTS-1:0] queue, pending;
  logic [SLOT_W-1:0]    ptr;
  logic                 flush, start, own, done;
  logic [LEN_W-1:0]     len;
  logic [THR_W-1:0]     thr;
  tx_result_t           inj, res;

  assign inj = '{underrun: inj_underrun_i, abort: inj_abort_i, coll: inj_coll_i};

  tx_slot_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .pending_i(pending), .ptr_i(ptr), .own_i(own), .done_i(done), .res_i(res),
    .queue_o(queue), .flush_o(flush), .len_o(len), .thr_o(thr)
  );

  tx_slot_seq u_seq (
    .clk_i, .rst_ni, .flush_i(flush), .queue_i(queue),
    .done_i(done), .done_ok_i(!res.abort && !res.underrun),
    .pending_o(pending), .ptr_o(ptr), .start_o(start),
    .ok_irq_o(tx_ok_irq_o), .err_irq_o(tx_err_irq_o)
  );

  tx_frame_model #(.FILL_BPC(FILL_BPC), .SEND_BPC(SEND_BPC)) u_model (
    .clk_i, .rst_ni, .flush_i(flush), .start_i(start),
    .len_i(len), .thr_i(thr), .inj_i(inj),
    .own_o(own), .done_o(done), .res_o(res), .busy_o(tx_busy_o)
  );

  a_r11_flush_idles_wire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !tx_busy_o);
endmodule

// File: tb/tx_slot_engine_tb_top.sv
module tx_slot_engine_tb_top;
  logic clk = 0, rst_n = 0;
  logic we = 0; logic [5:0] addr = 0; logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic inj_u = 0, inj_a = 0; logic [3:0] inj_c = 0;
  logic busy, okirq, errirq;
  int n_chk = 0, n_bad = 0, cyc = 0, n_ok = 0, n_err = 0, n_both = 0, n_wide = 0;
  logic prev_irq = 0;

  always #5 clk = ~clk;

  tx_slot_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .inj_underrun_i(inj_u), .inj_abort_i(inj_a), .inj_coll_i(inj_c),
    .tx_busy_o(busy), .tx_ok_irq_o(okirq), .tx_err_irq_o(errirq)
  );

  always @(posedge clk) cyc++;
  always @(negedge clk) if (rst_n) begin
    if (okirq) n_ok++;
    if (errirq) n_err++;
    if (okirq && errirq) n_both++;
    if ((okirq || errirq) && prev_irq) n_wide++;
    prev_irq = okirq || errirq;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic sw_reset();
    wr(6'h20, 32'h1);
  endtask

  // waits for a result bit (15, 14 or 30) in slot s; returns status and cycle
  task automatic wait_final(int s, output logic [31:0] st, output int t);
    t = -1;
    for (int i = 0; i < 4000; i++) begin
      rd(6'(4 * s), st);
      if (st[15] || st[14] || st[30]) begin t = cyc; break; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(6'(4 * i), d); check("R1 reg after reset", d, 0);
    end
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 irqs", {30'b0, okirq, errirq}, 0);
  endtask

  task automatic t_addr_regs();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) wr(6'(16 + 4 * i), 32'hA5A5_0000 + 32'(i * 32'h1111));
    repeat (20) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd(6'(16 + 4 * i), d); check("R2 address readback", d, 32'hA5A5_0000 + 32'(i * 32'h1111));
      rd(6'(4 * i), d); check("R2 status untouched", d, 0);
    end
    check("R2 no transmission", {31'b0, busy}, 0);
  endtask

  task automatic t_ok_frame();
    logic [31:0] d; int t, ok0;
    sw_reset();
    inj_c = 4'h9; ok0 = n_ok;
    wr(6'h00, 32'hFFFF_E040);
    rd(6'h00, d); check("R3 masked write", d, 32'h003F_0040);
    wait_final(0, d, t);
    check("R6 clean status", d, 32'h093F_A040);
    repeat (3) @(negedge clk);
    check("R6 ok pulse", n_ok - ok0, 1);
    inj_c = 0;
  endtask

  task automatic t_threshold();
    logic [31:0] d; int t_busy, t_own;
    for (int m = 0; m < 2; m++) begin
      sw_reset();
      t_busy = -1; t_own = -1;
      wr(6'h00, (m == 0) ? 32'h0002_0200 : 32'h0000_0200);
      for (int i = 0; i < 3000 && (t_busy < 0 || t_own < 0); i++) begin
        rd(6'h00, d);
        if (busy && t_busy < 0) t_busy = cyc;
        if (d[13] && t_own < 0) t_own = cyc;
      end
      if (m == 0) check("R5 early start before own", {31'b0, t_busy >= 0 && t_busy < t_own}, 1);
      else check("R5 zero threshold waits for own", {31'b0, t_busy >= t_own && t_own >= 0}, 1);
      check("R4 own seen before result", {31'b0, !(d[15] && t_own == cyc && t_busy < 0)}, 1);
      wait_final(0, d, t_own);
      check("R4 own kept at completion", {31'b0, d[13]}, 1);
    end
  endtask

  task automatic t_errors();
    logic [31:0] d; int t, e0;
    sw_reset();
    e0 = n_err;
    inj_u = 1;
    wr(6'h00, 32'h0000_0080);
    wait_final(0, d, t);
    check("R7 underrun status", d, 32'h0000_6080);
    inj_u = 0; inj_a = 1; inj_c = 4'h3;
    wr(6'h04, 32'h0000_0100);
    wait_final(1, d, t);
    check("R8 abort status", d, 32'h4300_2100);
    inj_u = 1;
    wr(6'h08, 32'h0000_0010);
    wait_final(2, d, t);
    check("R8 abort beats underrun", d, 32'h4300_2010);
    inj_u = 0; inj_a = 0; inj_c = 0;
    repeat (3) @(negedge clk);
    check("R7 err pulses", n_err - e0, 3);
  endtask

  task automatic t_order();
    logic [31:0] d; int t0, t1, t2, t3, ok0;
    sw_reset();
    ok0 = n_ok;
    wr(6'h04, 32'h0000_0040);
    repeat (100) @(negedge clk);
    rd(6'h04, d); check("R9 out-of-turn slot waits", d, 32'h0000_0040);
    check("R9 no wire while waiting", {31'b0, busy}, 0);
    wr(6'h00, 32'h0000_0040);
    wait_final(0, d, t0);
    wait_final(1, d, t1);
    check("R9 slot0 before slot1", {31'b0, t0 < t1}, 1);
    wr(6'h08, 32'h0000_0100);
    wr(6'h0C, 32'h0000_0040);
    wr(6'h00, 32'h0000_0040);
    t0 = -1; t2 = -1; t3 = -1;
    for (int i = 0; i < 3000 && t0 < 0; i++) begin
      rd(6'h08, d); if (d[15] && t2 < 0) t2 = cyc;
      rd(6'h0C, d); if (d[15] && t3 < 0) t3 = cyc;
      rd(6'h00, d); if (d[15] && t0 < 0) t0 = cyc;
    end
    check("R9 wrap order 2,3,0", {31'b0, t2 >= 0 && t2 < t3 && t3 < t0}, 1);
    repeat (3) @(negedge clk);
    check("R12 one pulse per slot", n_ok - ok0, 5);
  endtask

  task automatic t_busy_write();
    logic [31:0] d; int t;
    sw_reset();
    wr(6'h00, 32'h0000_03E8);
    wr(6'h00, 32'h0000_0014);
    wait_final(0, d, t);
    check("R10 second write ignored", d, 32'h0000_A3E8);
  endtask

  task automatic t_sw_reset();
    logic [31:0] d; int t;
    sw_reset();
    wr(6'h10, 32'hDEAD_BEEF);
    wr(6'h00, 32'h0000_0010);
    wr(6'h04, 32'h0000_0010);
    wait_final(1, d, t);
    wr(6'h08, 32'h0001_1000);
    for (int i = 0; i < 200 && !busy; i++) @(negedge clk);
    sw_reset();
    check("R11 wire idle", {31'b0, busy}, 0);
    for (int i = 0; i < 4; i++) begin
      rd(6'(4 * i), d); check("R11 status cleared", d, 0);
    end
    rd(6'h10, d); check("R11 address kept", d, 32'hDEAD_BEEF);
    repeat (200) @(negedge clk);
    rd(6'h08, d); check("R11 cancelled slot stays idle", d, 0);
    wr(6'h00, 32'h0000_0020);
    wait_final(0, d, t);
    check("R11 rotation back at slot 0", d, 32'h0000_A020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_addr_regs();
    t_ok_frame();
    t_threshold();
    t_errors();
    t_order();
    t_busy_write();
    t_sw_reset();
    check("R12 never both irqs", n_both, 0);
    check("R12 pulses one cycle", n_wide, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule